// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 10/100 Ethernet transceiver, as a station-management controller would see them. A host reaches it through a plain synchronous register port. The port has a 5-bit register index, 16-bit write data, a read strobe and a write strobe, and it returns read data one cycle after a strobed read. The port accepts an access in every cycle and never stalls, so the block applies no back-pressure. The serial framing and the transceiver address belong to the logic in front of this block.

The block stores five registers: control, status, advertisement, interrupt source and interrupt mask. It returns fixed identifier, partner-ability and expansion words. Writing the control register can either reset the whole register set or complete autonegotiation at once. The `link_down` input is asynchronous. The block synchronizes it, and each change of the synchronized level updates the status bits and sets interrupt-source bits. A level interrupt goes high while any unmasked source bit is pending.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hard reset, control reads 0x3000, advertisement reads 0x01E1, mask and source read 0, and status starts at 0x7809. Once the `link_down` synchronizer has filled, the current link level is applied as one link update (see R9). With the link up, status then reads 0x782D and source reads 0x00C0.
- R2: Index 2 reads 0x0007, index 3 reads 0xC0D1, index 5 reads 0x0F71 and index 6 reads 0x0001. Writes to these indices change nothing.
- R3: A write to index 0 with bit 15 set restores every register to its R1 value. In the same cycle it applies a link update from the current synchronized link level.
- R4: A write to index 0 with bit 15 clear stores the write data ANDed with 0x7980 into control.
- R5: A write of the kind in R4 that has bit 12 set also sets status bit 5 in the same cycle.
- R6: A write to index 4 stores (data AND 0x2D7F) OR 0x0080 into advertisement.
- R7: Index 30 is the interrupt mask. It keeps write-data bits 7:0 and reads back zero-extended. `irq` follows a new mask in the cycle after the write.
- R8: A strobed read of index 29 returns the pending source bits, which sit in bits 7:0, and clears them in the same cycle.
- R9: A synchronized falling edge of the link (link_down 0 to 1) clears status bits 5 and 2 and sets source bit 4. A rising edge sets status bits 5 and 2 and sets source bits 7 and 6. Bits set by a link update survive a clearing read of index 29 in the same cycle.
- R10: Indices 17, 18, 27, 31 and every other undefined index read as 0, and writes to them change no register.
- R11: `irq` is high exactly when (source AND mask) is nonzero.
- R12: `rdata` is registered and updates only in the cycle after a read strobe, otherwise it holds its value. Without a read strobe, index 29 is never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe for the register at `addr` |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid one cycle after `rd_en` |
| link_down | input | 1 | Asynchronous link-down level |
| irq | output | 1 | Level interrupt: unmasked source bit pending |

## Verification
Most state errors show up at `rdata` only when a later read reaches the damaged register. A corrupted control, advertisement or status value therefore stays hidden until the next strobed read of that index, which then returns it one cycle later. Errors in the source or mask registers show on `irq` in the cycle right after the edge that produced them. An early or late link update shows up as a one-cycle shift in when `irq` rises or falls. The bench compares `rdata` and `irq` against a reference model on every clock, so both kinds of error are caught at the first cycle they reach a port.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int IRQ_W  = 8;

  localparam logic [ADDR_W-1:0] IDX_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] IDX_STAT    = 5'd1;
  localparam logic [ADDR_W-1:0] IDX_ID_HI   = 5'd2;
  localparam logic [ADDR_W-1:0] IDX_ID_LO   = 5'd3;
  localparam logic [ADDR_W-1:0] IDX_ADV     = 5'd4;
  localparam logic [ADDR_W-1:0] IDX_PARTNER = 5'd5;
  localparam logic [ADDR_W-1:0] IDX_EXPAND  = 5'd6;
  localparam logic [ADDR_W-1:0] IDX_SRC     = 5'd29;
  localparam logic [ADDR_W-1:0] IDX_MASK    = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_INIT   = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_INIT   = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_INIT    = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_KEEP   = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_KEEP    = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE   = 16'h0080;
  localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;
  localparam logic [DATA_W-1:0] ID_HI_VAL   = 16'h0007;
  localparam logic [DATA_W-1:0] ID_LO_VAL   = 16'hC0D1;
  localparam logic [DATA_W-1:0] PARTNER_VAL = 16'h0F71;
  localparam logic [DATA_W-1:0] EXPAND_VAL  = 16'h0001;

  localparam logic [IRQ_W-1:0]  SRC_LOST    = 8'h10;
  localparam logic [IRQ_W-1:0]  SRC_GAINED  = 8'hC0;
  localparam int                RST_BIT     = 15;
  localparam int                ANEG_BIT    = 12;
endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic upd,
  output logic level
);
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] chain;
  logic [CNT_W-1:0]  fill;
  logic              armed;
  logic              prev;
  logic              full;

  assign level = chain[STAGES-1];
  assign full  = (fill == CNT_W'(STAGES));
  assign upd   = armed ? (level != prev) : full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      fill  <= '0;
      armed <= 1'b0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      if (!full) fill <= fill + CNT_W'(1);
      if (upd) begin
        armed <= 1'b1;
        prev  <= level;
      end
    end
  end
endmodule

// File: rtl/phy_reg_core.sv
module phy_reg_core
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_upd,
  input  logic              link_lvl,
  output logic [DATA_W-1:0] rdata,
  output logic [IRQ_W-1:0]  src,
  output logic [IRQ_W-1:0]  mask
);
  logic [DATA_W-1:0] ctrl, stat, adv;
  logic [DATA_W-1:0] ctrl_n, stat_n, adv_n, rd_val;
  logic [IRQ_W-1:0]  src_n, mask_n;
  logic              soft_rst, apply_link;

  always_comb begin
    ctrl_n   = ctrl;
    stat_n   = stat;
    adv_n    = adv;
    src_n    = src;
    mask_n   = mask;
    soft_rst = 1'b0;
    if (wr_en) begin
      unique case (addr)
        IDX_CTRL: begin
          if (wdata[RST_BIT]) soft_rst = 1'b1;
          else begin
            ctrl_n = wdata & CTRL_KEEP;
            if (wdata[ANEG_BIT]) stat_n = stat_n | STAT_ANDONE;
          end
        end
        IDX_ADV:  adv_n  = (wdata & ADV_KEEP) | ADV_FORCE;
        IDX_MASK: mask_n = wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
    if (rd_en && addr == IDX_SRC) src_n = '0;
    apply_link = link_upd;
    if (soft_rst) begin
      ctrl_n     = CTRL_INIT;
      stat_n     = STAT_INIT;
      adv_n      = ADV_INIT;
      src_n      = '0;
      mask_n     = '0;
      apply_link = 1'b1;
    end
    if (apply_link) begin
      if (link_lvl) begin
        stat_n = stat_n & ~STAT_LINK;
        src_n  = src_n | SRC_LOST;
      end else begin
        stat_n = stat_n | STAT_LINK;
        src_n  = src_n | SRC_GAINED;
      end
    end
  end

  always_comb begin
    unique case (addr)
      IDX_CTRL:    rd_val = ctrl;
      IDX_STAT:    rd_val = stat;
      IDX_ID_HI:   rd_val = ID_HI_VAL;
      IDX_ID_LO:   rd_val = ID_LO_VAL;
      IDX_ADV:     rd_val = adv;
      IDX_PARTNER: rd_val = PARTNER_VAL;
      IDX_EXPAND:  rd_val = EXPAND_VAL;
      IDX_SRC:     rd_val = {{(DATA_W-IRQ_W){1'b0}}, src};
      IDX_MASK:    rd_val = {{(DATA_W-IRQ_W){1'b0}}, mask};
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_INIT;
      stat  <= STAT_INIT;
      adv   <= ADV_INIT;
      src   <= '0;
      mask  <= '0;
      rdata <= '0;
    end else begin
      ctrl <= ctrl_n;
      stat <= stat_n;
      adv  <= adv_n;
      src  <= src_n;
      mask <= mask_n;
      if (rd_en) rdata <= rd_val;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              link_down,
  output logic              irq
);
  logic             link_upd;
  logic             link_lvl;
  logic [IRQ_W-1:0] src;
  logic [IRQ_W-1:0] mask;

  phy_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (link_down),
    .upd      (link_upd),
    .level    (link_lvl)
  );

  phy_reg_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .link_upd (link_upd),
    .link_lvl (link_lvl),
    .rdata    (rdata),
    .src      (src),
    .mask     (mask)
  );

  assign irq = |(src & mask);
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
  import phy_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              link_upd
);
  a_r2_id_hi_const: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IDX_ID_HI) |=> (rdata == ID_HI_VAL));

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 5'd17 || addr == 5'd31)) |=> (rdata == '0));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r3_soft_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_CTRL && wdata[RST_BIT]) |=> !irq);

  a_r7_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_MASK && wdata[IRQ_W-1:0] == '0) |=> !irq);

  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IDX_SRC && !link_upd) |=> !irq);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .link_upd (link_upd)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        link_down = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .link_down(link_down), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference model
  logic [15:0] m_ctrl, m_stat, m_adv, m_rdata;
  logic [7:0]  m_src, m_mask;
  logic        m_irq, m_s1, m_s2, m_prev, m_arm;
  int          m_age;

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'd0:  return m_ctrl;
      5'd1:  return m_stat;
      5'd2:  return 16'h0007;
      5'd3:  return 16'hC0D1;
      5'd4:  return m_adv;
      5'd5:  return 16'h0F71;
      5'd6:  return 16'h0001;
      5'd29: return {8'h00, m_src};
      5'd30: return {8'h00, m_mask};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
      m_src = 0; m_mask = 0; m_rdata = 0; m_irq = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_arm = 0; m_age = 0;
    end else begin
      logic ev, lv, sr;
      ev = m_arm ? (m_s2 != m_prev) : (m_age == 2);
      lv = m_s2;
      sr = 0;
      if (rd_en) m_rdata = m_read(addr);
      if (rd_en && addr == 5'd29) m_src = 0;
      if (wr_en && addr == 5'd0) begin
        if (wdata[15]) sr = 1;
        else begin
          m_ctrl = wdata & 16'h7980;
          if (wdata[12]) m_stat[5] = 1'b1;
        end
      end
      if (wr_en && addr == 5'd4) m_adv = (wdata & 16'h2D7F) | 16'h0080;
      if (wr_en && addr == 5'd30) m_mask = wdata[7:0];
      if (sr) begin
        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
        m_src = 0; m_mask = 0;
      end
      if (ev || sr) begin
        if (lv) begin m_stat[5] = 0; m_stat[2] = 0; m_src[4] = 1; end
        else begin m_stat[5] = 1; m_stat[2] = 1; m_src[7] = 1; m_src[6] = 1; end
      end
      if (ev) begin m_arm = 1; m_prev = lv; end
      m_s2 = m_s1;
      m_s1 = link_down;
      if (m_age < 2) m_age++;
      m_irq = |(m_src & m_mask);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R11, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R12 rdata vs model", rdata, m_rdata);
      check("R11 irq vs model", {15'b0, irq}, {15'b0, m_irq});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    idle(4);
    rd(5'd0,  16'h3000, "R1 control reset");
    rd(5'd1,  16'h782D, "R1 status with link up");
    rd(5'd4,  16'h01E1, "R1 advert reset");
    rd(5'd30, 16'h0000, "R1 mask reset");
    // R12: address parked on source without strobe must not clear it
    addr = 5'd29; idle(3);
    rd(5'd29, 16'h00C0, "R1 R12 source after link apply");
    rd(5'd29, 16'h0000, "R8 source cleared by read");
    // R2
    rd(5'd2, 16'h0007, "R2 id hi");
    rd(5'd3, 16'hC0D1, "R2 id lo");
    rd(5'd5, 16'h0F71, "R2 partner");
    rd(5'd6, 16'h0001, "R2 expansion");
    wr(5'd2, 16'hFFFF);
    wr(5'd5, 16'h0000);
    rd(5'd2, 16'h0007, "R2 id after write");
    rd(5'd5, 16'h0F71, "R2 partner after write");
    // R9 link down
    link_down = 1; idle(4);
    rd(5'd1,  16'h7809, "R9 status link down");
    rd(5'd29, 16'h0010, "R9 source link down");
    // R4 / R5
    wr(5'd0, 16'h1000);
    rd(5'd0, 16'h1000, "R4 control stored");
    rd(5'd1, 16'h7829, "R5 aneg complete set");
    wr(5'd0, 16'h7FFF);
    rd(5'd0, 16'h7980, "R4 control masked");
    wr(5'd0, 16'h0100);
    rd(5'd0, 16'h0100, "R4 control no aneg");
    // R6
    wr(5'd4, 16'hFFFF);
    rd(5'd4, 16'h2DFF, "R6 advert all ones");
    wr(5'd4, 16'h0000);
    rd(5'd4, 16'h0080, "R6 advert forced bit");
    // R7
    wr(5'd30, 16'hFF12);
    rd(5'd30, 16'h0012, "R7 mask low byte");
    // R11 with link up: source C0 masked by 0x10
    wr(5'd30, 16'h0010);
    link_down = 0; idle(4);
    check("R11 irq masked off", {15'b0, irq}, 16'h0);
    wr(5'd30, 16'h00C0);
    check("R7 R11 irq after mask", {15'b0, irq}, 16'h1);
    rd(5'd29, 16'h00C0, "R8 source pending");
    check("R8 irq after clear", {15'b0, irq}, 16'h0);
    // R9 coincidence: link edge applied on the same edge as a clearing read
    link_down = 1; idle(2);
    rd(5'd29, 16'h0000, "R9 read at link edge");
    rd(5'd29, 16'h0010, "R9 bit survives clear");
    // R3 soft reset, link down
    wr(5'd30, 16'h00FF);
    wr(5'd4, 16'h0C00);
    wr(5'd0, 16'h8000);
    check("R3 irq after soft reset", {15'b0, irq}, 16'h0);
    rd(5'd0,  16'h3000, "R3 control");
    rd(5'd4,  16'h01E1, "R3 advert");
    rd(5'd30, 16'h0000, "R3 mask");
    rd(5'd1,  16'h7809, "R3 status link down");
    rd(5'd29, 16'h0010, "R3 source link down");
    // R10
    wr(5'd17, 16'hFFFF);
    wr(5'd31, 16'hFFFF);
    wr(5'd1, 16'hFFFF);
    rd(5'd17, 16'h0000, "R10 reg17");
    rd(5'd18, 16'h0000, "R10 reg18");
    rd(5'd27, 16'h0000, "R10 reg27");
    rd(5'd31, 16'h0000, "R10 reg31");
    rd(5'd10, 16'h0000, "R10 reg10");
    rd(5'd4,  16'h01E1, "R10 advert untouched");
    rd(5'd1,  16'h7809, "R10 status untouched");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule